// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block is the refill engine that runs after a translation cache miss. It accepts a 32-bit virtual address together with the current page table base, which selects the active process. It then walks a two-level page table held in memory and returns either the final page table entry, ready to be written into the translation cache, or a page-fault report.

The virtual address splits into three fields. The top 10 bits index the first-level (super) table. The next 10 bits index a second-level table. The low 12 bits are the offset within a 4 KB page. Each entry is a 32-bit word. Bit 0 is the valid flag. Bits 3:1 are the access rights: bit 1 read, bit 2 write, bit 3 execute. Bits 31:12 are the physical page number. For a first-level entry, that page number shifted left by 12 gives the base of the second-level table.

Reads go out through a single-word request port. The response may arrive any number of cycles later. An invalid first-level entry stops the walk at once, because no second-level table exists behind it. An invalid second-level entry means the page is not resident. Both cases are reported as faults, together with the level and the faulting address.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy_o, done_o, fault_o and mem_req_o are all low.
- R2: The first memory read of a walk is at ptbr + 4 * va[31:22], using the ptbr and va values present when start_i was accepted.
- R3: If bit 0 of the first-level entry is 0, the walk ends with fault_o high and fault_lvl_o = 0, after exactly one memory read.
- R4: When the first-level entry is valid, the second read is at {entry[31:12], 12'h000} + 4 * va[21:12].
- R5: If bit 0 of the second-level entry is 0, the walk ends with fault_o high and fault_lvl_o = 1, after exactly two memory reads.
- R6: When both entries are valid, done_o rises with fault_o low, and pte_o equals the second-level word unchanged (valid, rights and page number in the positions given above).
- R7: When a walk ends, fault_va_o equals the full virtual address of that walk.
- R8: mem_req_o is a one-cycle pulse per table level and is never high while idle. The walker waits in place for mem_rsp_valid_i for any number of cycles.
- R9: start_i is ignored while busy_o is high. A second start during a walk changes neither its addresses nor its result.
- R10: done_o is high for exactly one cycle, with busy_o high. In the following cycle both done_o and busy_o are low.
- R11: The page offset va[11:0] affects no memory address and no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a walk; taken only when idle |
| va_i | input | 32 | Virtual address to translate |
| ptbr_i | input | 32 | Byte address of the first-level table |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| fault_o | output | 1 | With done_o: the walk faulted |
| fault_lvl_o | output | 1 | Faulting level: 0 first, 1 second |
| fault_va_o | output | 32 | Virtual address of the finished walk |
| pte_o | output | 32 | Final entry on success |
| mem_req_o | output | 1 | Word-read request pulse |
| mem_addr_o | output | 32 | Byte address of the read |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 32 | Read data word |

## Verification
The bound checker watches several properties on every cycle. It checks that the request and the completion are single-cycle pulses and that no request is made while idle. It checks that every fault coincides with completion, that the captured address stays frozen for the whole walk, and that the first read address follows from the accepted base and index. The second-level address, the number of reads before an early fault, the exact returned entry and the offset having no effect depend on table contents. Only the bench's sweep can show these. That sweep covers all 1024 first-level indices, two table bases, varying response latency and starts issued during a walk.

// File: rtl/pw_pkg.sv
package pw_pkg;

   typedef enum logic [2:0] {
      PW_IDLE,
      PW_RD1,
      PW_WT1,
      PW_RD2,
      PW_WT2,
      PW_OK,
      PW_FLT
   } pw_state_e;

   // Entry layout: bit positions decoded by the walker and by the cache that loads it
   localparam int unsigned PW_VALID_BIT  = 0;
   localparam int unsigned PW_RIGHTS_LSB = 1;
   localparam int unsigned PW_RIGHTS_W   = 3;

endpackage

// File: rtl/pw_addr_form.sv
// Entry address = table base + index * entry size
module pw_addr_form #(
   parameter int unsigned AW          = 32,
   parameter int unsigned IDX_W       = 10,
   parameter int unsigned ENTRY_BYTES = 4
) (
   input  logic [AW-1:0]    base_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [AW-1:0]    addr_o
);

   localparam int unsigned SH = $clog2(ENTRY_BYTES);
   localparam bit POW2 = ((1 << SH) == ENTRY_BYTES);

   generate
      if (IDX_W + SH > AW) begin : g_bad
         $error("pw_addr_form: index does not fit in address width");
      end
      if (POW2) begin : g_shift
         assign addr_o = base_i + (AW'(idx_i) << SH);
      end else begin : g_mult
         assign addr_o = base_i + (AW'(idx_i) * AW'(ENTRY_BYTES));
      end
   endgenerate

endmodule

// File: rtl/pw_entry_dec.sv
// Turns a table entry's page number into the base of the next table
module pw_entry_dec #(
   parameter int unsigned AW    = 32,
   parameter int unsigned PPN_W = 20,
   parameter int unsigned OFF_W = 12
) (
   input  logic [PPN_W-1:0] ppn_i,
   output logic [AW-1:0]    next_base_o
);

   generate
      if (PPN_W + OFF_W > AW) begin : g_bad
         $error("pw_entry_dec: page number plus offset exceed address width");
      end else if (PPN_W + OFF_W == AW) begin : g_exact
         assign next_base_o = {ppn_i, {OFF_W{1'b0}}};
      end else begin : g_pad
         assign next_base_o = {{(AW-PPN_W-OFF_W){1'b0}}, ppn_i, {OFF_W{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/pw_fsm.sv
module pw_fsm
   import pw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  logic      rsp_valid_i,
   input  logic      ent_valid_i,
   output pw_state_e state_o
);

   pw_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         PW_IDLE: if (start_i) state_d = PW_RD1;
         PW_RD1:  state_d = PW_WT1;
         PW_WT1:  if (rsp_valid_i) state_d = ent_valid_i ? PW_RD2 : PW_FLT;
         PW_RD2:  state_d = PW_WT2;
         PW_WT2:  if (rsp_valid_i) state_d = ent_valid_i ? PW_OK : PW_FLT;
         PW_OK:   state_d = PW_IDLE;
         PW_FLT:  state_d = PW_IDLE;
         default: state_d = PW_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= PW_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pw_pkg::*;
#(
   parameter int unsigned VA_W        = 32,
   parameter int unsigned AW          = 32,
   parameter int unsigned PTE_W       = 32,
   parameter int unsigned L1_W        = 10,
   parameter int unsigned L2_W        = 10,
   parameter int unsigned OFF_W       = 12,
   parameter int unsigned ENTRY_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [VA_W-1:0]  va_i,
   input  logic [AW-1:0]    ptbr_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             fault_o,
   output logic             fault_lvl_o,
   output logic [VA_W-1:0]  fault_va_o,
   output logic [PTE_W-1:0] pte_o,
   output logic             mem_req_o,
   output logic [AW-1:0]    mem_addr_o,
   input  logic             mem_rsp_valid_i,
   input  logic [PTE_W-1:0] mem_rsp_data_i
);

   localparam int unsigned PPN_W = PTE_W - OFF_W;
   localparam int unsigned L1_LSB = OFF_W + L2_W;

   generate
      if (L1_W + L2_W + OFF_W != VA_W) begin : g_bad_split
         $error("pt_walker: index and offset widths must sum to VA_W");
      end
      if (PTE_W <= OFF_W + PW_RIGHTS_LSB + PW_RIGHTS_W - 1) begin : g_bad_pte
         $error("pt_walker: entry too narrow for its fields");
      end
   endgenerate

   pw_state_e        state;
   logic [VA_W-1:0]  va_q;
   logic [AW-1:0]    ptbr_q;
   logic [PTE_W-1:0] ent_q;
   logic             lvl_q;
   logic [AW-1:0]    l1_addr, l2_addr, l2_base;
   logic             rsp_ent_valid;

   assign rsp_ent_valid = mem_rsp_data_i[PW_VALID_BIT];

   pw_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .rsp_valid_i (mem_rsp_valid_i),
      .ent_valid_i (rsp_ent_valid),
      .state_o     (state)
   );

   pw_addr_form #(.AW(AW), .IDX_W(L1_W), .ENTRY_BYTES(ENTRY_BYTES)) u_l1_addr (
      .base_i (ptbr_q),
      .idx_i  (va_q[L1_LSB +: L1_W]),
      .addr_o (l1_addr)
   );

   pw_entry_dec #(.AW(AW), .PPN_W(PPN_W), .OFF_W(OFF_W)) u_dec (
      .ppn_i       (ent_q[OFF_W +: PPN_W]),
      .next_base_o (l2_base)
   );

   pw_addr_form #(.AW(AW), .IDX_W(L2_W), .ENTRY_BYTES(ENTRY_BYTES)) u_l2_addr (
      .base_i (l2_base),
      .idx_i  (va_q[OFF_W +: L2_W]),
      .addr_o (l2_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q   <= '0;
         ptbr_q <= '0;
         ent_q  <= '0;
         lvl_q  <= 1'b0;
      end else begin
         if (state == PW_IDLE && start_i) begin
            va_q   <= va_i;
            ptbr_q <= ptbr_i;
         end
         if (state == PW_WT1 && mem_rsp_valid_i) begin
            ent_q <= mem_rsp_data_i;
            lvl_q <= 1'b0;
         end
         if (state == PW_WT2 && mem_rsp_valid_i) begin
            ent_q <= mem_rsp_data_i;
            lvl_q <= 1'b1;
         end
      end
   end

   assign busy_o      = (state != PW_IDLE);
   assign done_o      = (state == PW_OK) || (state == PW_FLT);
   assign fault_o     = (state == PW_FLT);
   assign fault_lvl_o = lvl_q;
   assign fault_va_o  = va_q;
   assign pte_o       = ent_q;
   assign mem_req_o   = (state == PW_RD1) || (state == PW_RD2);
   assign mem_addr_o  = (state == PW_RD2) ? l2_addr : l1_addr;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
   parameter int unsigned VA_W        = 32,
   parameter int unsigned AW          = 32,
   parameter int unsigned L1_W        = 10,
   parameter int unsigned ENTRY_BYTES = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [VA_W-1:0] va_i,
   input logic [AW-1:0]   ptbr_i,
   input logic            busy_o,
   input logic            done_o,
   input logic            fault_o,
   input logic [VA_W-1:0] fault_va_o,
   input logic            mem_req_o,
   input logic [AW-1:0]   mem_addr_o
);

   // R8
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o);

   // R8
   no_idle_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !mem_req_o);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   // R10
   done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> busy_o);

   // R3
   fault_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> done_o);

   // R9
   va_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(fault_va_o));

   // R2
   l1_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> (mem_req_o &&
         mem_addr_o == $past(ptbr_i) +
            AW'($past(va_i[VA_W-1 -: L1_W])) * AW'(ENTRY_BYTES)));

endmodule

bind pt_walker pt_walker_chk #(
   .VA_W(VA_W), .AW(AW), .L1_W(L1_W), .ENTRY_BYTES(ENTRY_BYTES)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .va_i       (va_i),
   .ptbr_i     (ptbr_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .fault_o    (fault_o),
   .fault_va_o (fault_va_o),
   .mem_req_o  (mem_req_o),
   .mem_addr_o (mem_addr_o)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] va_i = '0;
   logic [31:0] ptbr_i = '0;
   logic        busy_o, done_o, fault_o, fault_lvl_o, mem_req_o;
   logic [31:0] fault_va_o, pte_o, mem_addr_o;
   logic        mem_rsp_valid_i = 1'b0;
   logic [31:0] mem_rsp_data_i = '0;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   pt_walker dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i), .ptbr_i(ptbr_i),
      .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o), .fault_lvl_o(fault_lvl_o),
      .fault_va_o(fault_va_o), .pte_o(pte_o), .mem_req_o(mem_req_o),
      .mem_addr_o(mem_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
      .mem_rsp_data_i(mem_rsp_data_i)
   );

   localparam logic [31:0] BASE_A = 32'h0010_0000;
   localparam logic [31:0] BASE_B = 32'h0020_0000;

   // Table contents computed from the address
   function automatic logic [31:0] l1_word(logic [31:0] base, int unsigned i);
      int unsigned ppn = 32'h40000 + i + ((base == BASE_B) ? 32'h400 : 0);
      logic [2:0]  rt  = 3'(i % 8);
      logic        v   = (i % 3) != 0;
      return {ppn[19:0], 8'h00, rt, v};
   endfunction

   function automatic logic [31:0] l2_word(int unsigned t, int unsigned i);
      int unsigned ppn = (t * 7 + i * 13) & 32'hFFFFF;
      logic [2:0]  rt  = 3'((t + i) % 8);
      logic        v   = ((t + i) % 5) != 4;
      return {ppn[19:0], 8'h00, rt, v};
   endfunction

   function automatic logic [31:0] mem_word(logic [31:0] a);
      int unsigned i = (a >> 2) & 32'h3FF;
      if (a >= 32'h4000_0000) return l2_word((a >> 12) - 32'h40000, i);
      return l1_word(a & 32'hFFFF_F000, i);
   endfunction

   // Memory model with programmable response latency
   int          lat_g = 0;
   int          rd_total = 0;
   logic [31:0] last_a = '0, prev_a = '0, pend_a = '0;
   bit          pend = 0;
   int          cnt = 0;

   always @(negedge clk) begin
      mem_rsp_valid_i <= 1'b0;
      if (pend) begin
         if (cnt == 0) begin
            mem_rsp_valid_i <= 1'b1;
            mem_rsp_data_i  <= mem_word(pend_a);
            pend = 0;
         end else cnt = cnt - 1;
      end
      if (rst_n && mem_req_o) begin
         pend = 1; cnt = lat_g; pend_a = mem_addr_o;
         prev_a = last_a; last_a = mem_addr_o; rd_total = rd_total + 1;
      end
   end

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One walk; optionally a second start with another address mid-walk
   task automatic walk(logic [31:0] va, logic [31:0] base, int lat, bit intrude,
                       output logic [31:0] pte_r);
      int unsigned l1i = va[31:22];
      int unsigned l2i = va[21:12];
      logic [31:0] e1 = l1_word(base, l1i);
      logic [31:0] a1 = base + l1i * 4;
      logic [31:0] a2 = {e1[31:12], 12'h000} + l2i * 4;
      logic [31:0] e2 = l2_word(e1[31:12] - 32'h40000, l2i);
      int          r0, waited;
      lat_g = lat;
      r0 = rd_total;
      @(negedge clk);
      start_i = 1'b1; va_i = va; ptbr_i = base;
      @(negedge clk);
      start_i = 1'b0;
      va_i = ~va; ptbr_i = BASE_B ^ base ^ BASE_A;
      waited = 0;
      if (intrude) begin
         @(negedge clk);
         start_i = 1'b1; va_i = va ^ 32'hFFC0_0000;
         @(negedge clk);
         start_i = 1'b0;
         waited = 2;
      end
      while (!done_o && waited < 100) begin
         @(negedge clk);
         waited++;
      end
      chk(done_o, "R8 walk completes", 32'(done_o), 32'd1);
      chk(fault_va_o == va, "R7 fault_va", fault_va_o, va);
      if (!e1[0]) begin
         chk(rd_total - r0 == 1, "R3 one read", rd_total - r0, 1);
         chk(last_a == a1, "R2 l1 addr", last_a, a1);
         chk(fault_o && !fault_lvl_o, "R3 fault level 0", {fault_o, fault_lvl_o}, 32'h2);
      end else begin
         chk(rd_total - r0 == 2, "R5 two reads", rd_total - r0, 2);
         chk(prev_a == a1, "R2 l1 addr", prev_a, a1);
         chk(last_a == a2, "R4 l2 addr", last_a, a2);
         if (!e2[0])
            chk(fault_o && fault_lvl_o, "R5 fault level 1", {fault_o, fault_lvl_o}, 32'h3);
         else begin
            chk(!fault_o, "R6 no fault", 32'(fault_o), 0);
            chk(pte_o == e2, "R6 pte", pte_o, e2);
         end
      end
      if (intrude) chk(fault_va_o == va, "R9 start ignored while busy", fault_va_o, va);
      pte_r = {fault_o, fault_lvl_o} == 2'b10 ? 32'hDEAD_0000 : pte_o;
      if (fault_o) pte_r = {30'h0, fault_o, fault_lvl_o};
      @(negedge clk);
      chk(!done_o && !busy_o, "R10 done one cycle", {done_o, busy_o}, 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] p0, p1;
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o && !fault_o && !mem_req_o, "R1 reset state",
          {busy_o, done_o, fault_o, mem_req_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy_o && !mem_req_o, "R1 idle after reset", {busy_o, mem_req_o}, 0);

      // Sweep of every first-level index, two bases, latencies 0..3
      for (int i = 0; i < 1024; i++) begin
         logic [31:0] va;
         va = {10'(i), 10'((i * 37 + 5) % 1024), 12'((i * 291) % 4096)};
         walk(va, (i % 2) ? BASE_B : BASE_A, i % 4, 1'b0, p0);
      end

      // R11: offset has no effect
      for (int k = 0; k < 16; k++) begin
         logic [31:0] vb;
         vb = {10'(k * 61 + 1), 10'(k * 97 + 3), 12'h000};
         walk(vb, BASE_A, k % 3, 1'b0, p0);
         walk(vb | 32'hFFF, BASE_A, (k + 1) % 3, 1'b0, p1);
         chk(p0 == p1, "R11 offset ignored", p1, p0);
      end

      // R9: start during a slow walk
      for (int k = 0; k < 8; k++) begin
         walk({10'(k * 113 + 2), 10'(k * 7), 12'h5A5}, BASE_B, 3, 1'b1, p0);
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule